// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

This block turns interrupt events from on-chip clients into fixed 32-byte vectors and stores them in a circular buffer in memory, using a plain dword write port. It keeps a byte-granular write pointer, takes read-pointer updates from the consumer, and raises an interrupt line while unread entries remain. It can also write the write-pointer word to a separate memory location after each vector.

Each vector is eight dwords. It is stored at the ring base, which is 256-byte aligned, plus the write pointer. Both pointers count bytes, step by 32 and wrap at the ring length, which is four bytes times two to the power of the size field. When the ring fills up, the block does one of two things. In overwrite mode it keeps writing over the oldest vectors and sets a sticky flag in the write-pointer word, so the consumer can resume at the write pointer plus 32. In stall mode it holds off new events until the consumer frees space.

Top module: `ivr_producer`

## Requirements
- R1: After reset, and in any cycle after the ring enable is low, the write pointer, the read pointer and the overflow flag are zero, and `ev_ready` and `mem_wvalid` are low.
- R2: An accepted event is stored as eight dword writes, one after another, at byte addresses `{cfg_base_hi, 8'h00} + wptr + 4*k` for k = 0..7 in that order.
- R3: Dword 0 holds the client id in [7:0], the source id in [15:8], the ring id in [23:16], the VM id in [27:24] and the VM-id source flag in bit 31. All other bits are zero.
- R4: Dword 1 holds stamp[31:0]. Dword 2 holds stamp[47:32] in [15:0] and the stamp source flag in bit 31. Dword 3 holds the address-space id in [15:0] and its source flag in bit 31. Dwords 4..7 hold payload[32k+31:32k] for k = 0..3. All other bits are zero.
- R5: The write pointer advances by 32, modulo the ring length in bytes, only in the cycle the eighth dword is accepted. The ring length is 4·2^s bytes, where s is `cfg_size_log2` clamped to the range 4..14. `wptr_word` shows the write pointer in bits [15:0] and the overflow flag in bit 31.
- R6: A `rptr_wr` pulse loads `rptr_val` masked to the ring length. `irq` is high exactly when both enables are set and either the write pointer differs from the read pointer or the overflow flag is set.
- R7: With overflow detection on, a vector whose commit finds the ring full (write pointer plus 32, wrapped, equals the read pointer) is still stored, and the overflow flag is set and stays set.
- R8: A `cfg_ovf_clr` pulse clears the overflow flag. If a clear and an overflow-setting commit fall in the same cycle, the flag ends up set.
- R9: With overflow detection off, `ev_ready` is low while the ring is full.
- R10: With writeback enabled, each commit is followed by one write of the updated write-pointer word to `cfg_wb_addr`. With writeback disabled there is no such write.
- R11: While a write is offered and not accepted, its address and data hold steady. `ev_ready` stays low from acceptance until the vector, and any writeback, is finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_en | input | 1 | Ring enable; low clears the pointers |
| cfg_irq_en | input | 1 | Interrupt output enable |
| cfg_size_log2 | input | 4 | log2 of ring length in dwords |
| cfg_ovf_en | input | 1 | 1 = overwrite with flag, 0 = stall when full |
| cfg_ovf_clr | input | 1 | Pulse to clear the overflow flag |
| cfg_wb_en | input | 1 | Write-pointer writeback enable |
| cfg_base_hi | input | 32 | Ring base address bits [39:8] |
| cfg_wb_addr | input | 40 | Writeback byte address |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted when both are high |
| ev_client | input | 8 | Client id |
| ev_source | input | 8 | Source id |
| ev_ring | input | 8 | Ring id |
| ev_vmid | input | 4 | VM id |
| ev_vmid_src | input | 1 | VM id source flag |
| ev_stamp | input | 48 | Timestamp |
| ev_stamp_src | input | 1 | Timestamp source flag |
| ev_pasid | input | 16 | Address-space id |
| ev_pasid_src | input | 1 | Address-space id source flag |
| ev_payload | input | 128 | Four source-data dwords |
| rptr_wr | input | 1 | Read-pointer update strobe |
| rptr_val | input | 16 | New read pointer in bytes |
| wptr_word | output | 32 | Write pointer and overflow flag |
| mem_wvalid | output | 1 | Dword write offered |
| mem_wready | input | 1 | Dword write accepted |
| mem_waddr | output | 40 | Write byte address |
| mem_wdata | output | 32 | Write data |
| irq | output | 1 | Unread entries pending |

## Verification
Two functions can act on the overflow flag in the same cycle: a commit that finds the ring full, and the clear strobe. The bench fills a small ring, holds the clear strobe high across the commit of the vector that fills it, and then judges the result through the writeback dword, which must carry bit 31 set. A second coincidence is a read-pointer update landing on a commit edge, where fullness must be judged on the old read pointer. A behavioural model, compared every cycle, scores both cases, along with throttled write acceptance.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    localparam int VEC_DWORDS = 8;
    localparam int VEC_BYTES  = 32;

    typedef struct packed {
        logic [7:0]   client;
        logic [7:0]   source;
        logic [7:0]   ring;
        logic [3:0]   vmid;
        logic         vmid_src;
        logic [47:0]  stamp;
        logic         stamp_src;
        logic [15:0]  pasid;
        logic         pasid_src;
        logic [127:0] payload;
    } ivr_event_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VEC,
        ST_WB
    } ivr_state_e;

    function automatic int ivr_clamp(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [31:0] ivr_word(input ivr_event_t e, input logic [2:0] idx);
        logic [31:0] w;
        case (idx)
            3'd0:    w = {e.vmid_src, 3'b000, e.vmid, e.ring, e.source, e.client};
            3'd1:    w = e.stamp[31:0];
            3'd2:    w = {e.stamp_src, 15'd0, e.stamp[47:32]};
            3'd3:    w = {e.pasid_src, 15'd0, e.pasid};
            3'd4:    w = e.payload[31:0];
            3'd5:    w = e.payload[63:32];
            3'd6:    w = e.payload[95:64];
            default: w = e.payload[127:96];
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ivr_ptr.sv
module ivr_ptr
    import ivr_pkg::*;
#(
    parameter int PTR_W    = 16,
    parameter int SZ_W     = 4,
    parameter int MIN_LOG2 = 4,
    parameter int MAX_LOG2 = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ring_en,
    input  logic             intr_en,
    input  logic             ovf_en,
    input  logic             ovf_clr,
    input  logic [SZ_W-1:0]  size_log2,
    input  logic             rptr_wr,
    input  logic [PTR_W-1:0] rptr_in,
    input  logic             commit,
    output logic [PTR_W-1:0] wptr,
    output logic             ovf,
    output logic             full,
    output logic             irq,
    output logic [31:0]      word_next
);

    localparam int PAD_W = 31 - PTR_W;

    logic [PTR_W-1:0] rptr, mask, wstep, wptr_n, rptr_n;
    logic             ovf_n;
    int               eff;

    always_comb begin
        eff = ivr_clamp(int'(size_log2), MIN_LOG2, MAX_LOG2);
        for (int i = 0; i < PTR_W; i++) begin
            mask[i] = (i < eff + 2);
        end
    end

    assign wstep = (wptr + PTR_W'(VEC_BYTES)) & mask;
    assign full  = (wstep == rptr);

    always_comb begin
        if (!ring_en) begin
            wptr_n = '0;
            rptr_n = '0;
            ovf_n  = 1'b0;
        end else begin
            wptr_n = commit  ? wstep : wptr;
            rptr_n = rptr_wr ? (rptr_in & mask) : rptr;
            if (commit && ovf_en && full) begin
                ovf_n = 1'b1;
            end else if (ovf_clr) begin
                ovf_n = 1'b0;
            end else begin
                ovf_n = ovf;
            end
        end
    end

    assign word_next = {ovf_n, {PAD_W{1'b0}}, wptr_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            ovf  <= 1'b0;
        end else begin
            wptr <= wptr_n;
            rptr <= rptr_n;
            ovf  <= ovf_n;
        end
    end

    assign irq = ring_en && intr_en && ((wptr != rptr) || ovf);

    // R5: the write pointer moves only on a commit
    a_r5_wptr_holds: assert property (@(posedge clk) disable iff (rst)
        (ring_en && !commit) |=> (wptr == $past(wptr)));

    // R1: a disabled ring leaves its pointers and flag cleared
    a_r1_disable_clears: assert property (@(posedge clk) disable iff (rst)
        (!ring_en) |=> (wptr == '0 && rptr == '0 && !ovf));

    // R7: committing into a full ring sets the sticky flag
    a_r7_overflow_sets: assert property (@(posedge clk) disable iff (rst)
        (ring_en && commit && ovf_en && full) |=> ovf);

    // R8: a clear without a coinciding commit removes the flag
    a_r8_clear_works: assert property (@(posedge clk) disable iff (rst)
        (ring_en && ovf_clr && !commit) |=> !ovf);

endmodule

// File: rtl/ivr_seq.sv
module ivr_seq
    import ivr_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int ADDR_W = 40,
    parameter int BASE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ring_en,
    input  logic              wb_en,
    input  logic              can_accept,
    input  logic              ev_valid,
    input  ivr_event_t        ev_in,
    output logic              ev_ready,
    input  logic [BASE_W-1:0] base,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [31:0]       word_next,
    output logic              mem_wvalid,
    input  logic              mem_wready,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [31:0]       mem_wdata,
    output logic              commit
);

    localparam int ALIGN_W = ADDR_W - BASE_W;
    localparam int IDX_W   = $clog2(VEC_DWORDS);

    ivr_state_e        st;
    logic [IDX_W-1:0]  idx;
    ivr_event_t        held;
    logic [31:0]       wb_data;
    logic [ADDR_W-1:0] vec_base;

    assign vec_base = {base, {ALIGN_W{1'b0}}};
    assign ev_ready = ring_en && (st == ST_IDLE) && can_accept;
    assign commit   = (st == ST_VEC) && mem_wready && (idx == IDX_W'(VEC_DWORDS - 1));

    always_comb begin
        mem_wvalid = 1'b0;
        mem_waddr  = '0;
        mem_wdata  = '0;
        case (st)
            ST_VEC: begin
                mem_wvalid = 1'b1;
                mem_waddr  = vec_base + ADDR_W'(wptr) + ADDR_W'({idx, 2'b00});
                mem_wdata  = ivr_word(held, idx);
            end
            ST_WB: begin
                mem_wvalid = 1'b1;
                mem_waddr  = wb_addr;
                mem_wdata  = wb_data;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !ring_en) begin
            st      <= ST_IDLE;
            idx     <= '0;
            held    <= '0;
            wb_data <= '0;
        end else begin
            case (st)
                ST_IDLE: if (ev_valid && ev_ready) begin
                    st   <= ST_VEC;
                    idx  <= '0;
                    held <= ev_in;
                end
                ST_VEC: if (mem_wready) begin
                    idx <= idx + 1'b1;
                    if (commit) begin
                        wb_data <= word_next;
                        st      <= wb_en ? ST_WB : ST_IDLE;
                    end
                end
                ST_WB: if (mem_wready) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R11: an offered write holds its address and data until taken
    a_r11_write_holds: assert property (@(posedge clk) disable iff (rst)
        (mem_wvalid && !mem_wready && ring_en)
        |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));

    // R11: no second acceptance right behind the first
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_ready) |=> !ev_ready);

    // R10: writeback follows the commit at the programmed address
    a_r10_writeback_follows: assert property (@(posedge clk) disable iff (rst)
        (commit && wb_en && ring_en) |=> (mem_wvalid && mem_waddr == $past(wb_addr)));

endmodule

// File: rtl/ivr_producer.sv
module ivr_producer
    import ivr_pkg::*;
#(
    parameter int MIN_LOG2 = 4,
    parameter int MAX_LOG2 = 14,
    parameter int PTR_W    = MAX_LOG2 + 2,
    parameter int SZ_W     = $clog2(MAX_LOG2 + 1),
    parameter int ADDR_W   = 40,
    parameter int BASE_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_ring_en,
    input  logic              cfg_irq_en,
    input  logic [SZ_W-1:0]   cfg_size_log2,
    input  logic              cfg_ovf_en,
    input  logic              cfg_ovf_clr,
    input  logic              cfg_wb_en,
    input  logic [BASE_W-1:0] cfg_base_hi,
    input  logic [ADDR_W-1:0] cfg_wb_addr,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [7:0]        ev_client,
    input  logic [7:0]        ev_source,
    input  logic [7:0]        ev_ring,
    input  logic [3:0]        ev_vmid,
    input  logic              ev_vmid_src,
    input  logic [47:0]       ev_stamp,
    input  logic              ev_stamp_src,
    input  logic [15:0]       ev_pasid,
    input  logic              ev_pasid_src,
    input  logic [127:0]      ev_payload,
    input  logic              rptr_wr,
    input  logic [PTR_W-1:0]  rptr_val,
    output logic [31:0]       wptr_word,
    output logic              mem_wvalid,
    input  logic              mem_wready,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [31:0]       mem_wdata,
    output logic              irq
);

    localparam int PAD_W = 31 - PTR_W;

    ivr_event_t       ev;
    logic [PTR_W-1:0] wptr;
    logic             ovf, full, commit;
    logic [31:0]      word_next;

    always_comb begin
        ev.client    = ev_client;
        ev.source    = ev_source;
        ev.ring      = ev_ring;
        ev.vmid      = ev_vmid;
        ev.vmid_src  = ev_vmid_src;
        ev.stamp     = ev_stamp;
        ev.stamp_src = ev_stamp_src;
        ev.pasid     = ev_pasid;
        ev.pasid_src = ev_pasid_src;
        ev.payload   = ev_payload;
    end

    ivr_ptr #(
        .PTR_W(PTR_W), .SZ_W(SZ_W), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)
    ) u_ptr (
        .clk(clk), .rst(rst), .ring_en(cfg_ring_en), .intr_en(cfg_irq_en),
        .ovf_en(cfg_ovf_en), .ovf_clr(cfg_ovf_clr), .size_log2(cfg_size_log2),
        .rptr_wr(rptr_wr), .rptr_in(rptr_val), .commit(commit),
        .wptr(wptr), .ovf(ovf), .full(full), .irq(irq), .word_next(word_next)
    );

    ivr_seq #(
        .PTR_W(PTR_W), .ADDR_W(ADDR_W), .BASE_W(BASE_W)
    ) u_seq (
        .clk(clk), .rst(rst), .ring_en(cfg_ring_en), .wb_en(cfg_wb_en),
        .can_accept(cfg_ovf_en || !full), .ev_valid(ev_valid), .ev_in(ev),
        .ev_ready(ev_ready), .base(cfg_base_hi), .wb_addr(cfg_wb_addr),
        .wptr(wptr), .word_next(word_next), .mem_wvalid(mem_wvalid),
        .mem_wready(mem_wready), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .commit(commit)
    );

    assign wptr_word = {ovf, {PAD_W{1'b0}}, wptr};

    // R9: stall mode never takes an event into a full ring
    a_r9_stall_when_full: assert property (@(posedge clk) disable iff (rst)
        (!cfg_ovf_en && full) |-> !ev_ready);

endmodule

// File: tb/tb_ivr_producer.sv
module tb_ivr_producer;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_ring_en = 0, cfg_irq_en = 0, cfg_ovf_en = 0, cfg_ovf_clr = 0, cfg_wb_en = 0;
    logic [3:0]   cfg_size_log2 = 4'd5;
    logic [31:0]  cfg_base_hi = 32'h0012_3400;
    logic [39:0]  cfg_wb_addr = 40'h00_0000_1000;
    logic         ev_valid = 0;
    logic         ev_ready;
    logic [7:0]   ev_client = 0, ev_source = 0, ev_ring = 0;
    logic [3:0]   ev_vmid = 0;
    logic         ev_vmid_src = 0, ev_stamp_src = 0, ev_pasid_src = 0;
    logic [47:0]  ev_stamp = 0;
    logic [15:0]  ev_pasid = 0;
    logic [127:0] ev_payload = 0;
    logic         rptr_wr = 0;
    logic [15:0]  rptr_val = 0;
    logic [31:0]  wptr_word;
    logic         mem_wvalid, mem_wready = 1'b1;
    logic [39:0]  mem_waddr;
    logic [31:0]  mem_wdata;
    logic         irq;

    ivr_producer dut (
        .clk(clk), .rst(rst), .cfg_ring_en(cfg_ring_en), .cfg_irq_en(cfg_irq_en),
        .cfg_size_log2(cfg_size_log2), .cfg_ovf_en(cfg_ovf_en), .cfg_ovf_clr(cfg_ovf_clr),
        .cfg_wb_en(cfg_wb_en), .cfg_base_hi(cfg_base_hi), .cfg_wb_addr(cfg_wb_addr),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_client(ev_client),
        .ev_source(ev_source), .ev_ring(ev_ring), .ev_vmid(ev_vmid),
        .ev_vmid_src(ev_vmid_src), .ev_stamp(ev_stamp), .ev_stamp_src(ev_stamp_src),
        .ev_pasid(ev_pasid), .ev_pasid_src(ev_pasid_src), .ev_payload(ev_payload),
        .rptr_wr(rptr_wr), .rptr_val(rptr_val), .wptr_word(wptr_word),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int  n_checks = 0, n_errors = 0;
    bit  done = 0;
    bit  throttle = 1;

    // reference model state
    int          m_w = 0, m_r = 0;
    bit          m_ovf = 0;
    logic [39:0] q_addr[$];
    logic [31:0] q_data[$];
    int          q_kind[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int ring_mask();
        int s = int'(cfg_size_log2);
        if (s < 4) s = 4;
        if (s > 14) s = 14;
        return (1 << (s + 2)) - 1;
    endfunction

    function automatic logic [31:0] model_word();
        return (m_ovf ? 32'h8000_0000 : 32'h0) | 32'(m_w);
    endfunction

    function automatic logic [31:0] pack_dw(input int k);
        case (k)
            0: return (32'(ev_vmid_src) << 31) | (32'(ev_vmid) << 24) | (32'(ev_ring) << 16)
                      | (32'(ev_source) << 8) | 32'(ev_client);
            1: return ev_stamp[31:0];
            2: return (32'(ev_stamp_src) << 31) | 32'(ev_stamp[47:32]);
            3: return (32'(ev_pasid_src) << 31) | 32'(ev_pasid);
            default: return ev_payload[32*(k-4) +: 32];
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit full_now, exp_ready, exp_irq, commit_now;
            full_now  = (((m_w + 32) & ring_mask()) == m_r);
            exp_ready = cfg_ring_en && (q_addr.size() == 0) && (cfg_ovf_en || !full_now);
            exp_irq   = cfg_ring_en && cfg_irq_en && ((m_w != m_r) || m_ovf);
            chk(wptr_word == model_word(), "R5/R7/R8", "wptr_word", wptr_word, model_word());
            chk(irq == exp_irq, "R6", "irq", irq, exp_irq);
            chk(ev_ready == exp_ready, "R9/R11", "ev_ready", ev_ready, exp_ready);
            chk(mem_wvalid == (q_addr.size() != 0), "R2", "mem_wvalid", mem_wvalid, q_addr.size() != 0);
            if (!cfg_ring_en) begin
                m_w = 0; m_r = 0; m_ovf = 0;
                q_addr.delete(); q_data.delete(); q_kind.delete();
            end else begin
                commit_now = 0;
                if (mem_wvalid && mem_wready && q_addr.size() != 0) begin
                    logic [39:0] ea;
                    logic [31:0] ed;
                    int          kd;
                    ea = q_addr.pop_front(); ed = q_data.pop_front(); kd = q_kind.pop_front();
                    chk(mem_waddr == ea, (kd == 8) ? "R10" : "R2", "mem_waddr", mem_waddr, ea);
                    chk(mem_wdata == ed, (kd == 8) ? "R10" : (kd == 0) ? "R3" : "R4",
                        "mem_wdata", mem_wdata, ed);
                    commit_now = (kd == 7);
                end
                if (commit_now && cfg_ovf_en && full_now) m_ovf = 1;
                else if (cfg_ovf_clr) m_ovf = 0;
                if (commit_now) begin
                    m_w = (m_w + 32) & ring_mask();
                    if (cfg_wb_en) begin
                        q_addr.push_back(cfg_wb_addr); q_data.push_back(model_word()); q_kind.push_back(8);
                    end
                end
                if (rptr_wr) m_r = int'(rptr_val) & ring_mask();
                if (ev_valid && ev_ready) begin
                    for (int k = 0; k < 8; k++) begin
                        q_addr.push_back({cfg_base_hi, 8'h00} + 40'(m_w) + 40'(4 * k));
                        q_data.push_back(pack_dw(k));
                        q_kind.push_back(k);
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        #1;
        mem_wready <= throttle ? (($urandom % 4) != 0) : 1'b1;
    end

    task automatic send_event();
        ev_client = 8'($urandom); ev_source = 8'($urandom); ev_ring = 8'($urandom);
        ev_vmid = 4'($urandom); ev_vmid_src = 1'($urandom);
        ev_stamp = {16'($urandom), 32'($urandom)}; ev_stamp_src = 1'($urandom);
        ev_pasid = 16'($urandom); ev_pasid_src = 1'($urandom);
        ev_payload = {$urandom, $urandom, $urandom, $urandom};
        ev_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (ev_ready) begin
                @(posedge clk); #1;
                ev_valid = 1'b0;
                break;
            end
        end
    endtask

    task automatic wait_idle();
        do begin @(posedge clk); #1; end while (q_addr.size() != 0);
        @(posedge clk); #1;
    endtask

    task automatic write_rptr(input int v);
        rptr_wr = 1'b1; rptr_val = 16'(v);
        @(posedge clk); #1;
        rptr_wr = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        chk(wptr_word == 0, "R1", "reset wptr_word", wptr_word, 0);
        chk(irq == 0, "R1", "reset irq", irq, 0);
        chk(mem_wvalid == 0, "R1", "reset mem_wvalid", mem_wvalid, 0);
        chk(ev_ready == 0, "R1", "reset ev_ready", ev_ready, 0);

        // basic traffic with wraparound, writeback on, throttled port
        cfg_ring_en = 1; cfg_irq_en = 1; cfg_ovf_en = 1; cfg_wb_en = 1; cfg_size_log2 = 4'd5;
        repeat (2) send_event();
        wait_idle();
        chk(wptr_word == 32'd64, "R5", "wptr after two vectors", wptr_word, 64);
        chk(irq == 1, "R6", "irq pending", irq, 1);
        write_rptr(64);
        repeat (3) send_event();
        wait_idle();
        chk(wptr_word == 32'd32, "R5", "wptr after wrap", wptr_word, 32);

        // overflow in overwrite mode
        write_rptr(m_w);
        repeat (4) send_event();
        wait_idle();
        chk(wptr_word[31] == 1'b1, "R7", "overflow flag set", wptr_word[31], 1);
        chk(irq == 1, "R6", "irq with overflow", irq, 1);
        cfg_ovf_clr = 1; @(posedge clk); #1; cfg_ovf_clr = 0;
        chk(wptr_word[31] == 1'b0, "R8", "overflow cleared", wptr_word[31], 0);

        // clear held across the commit that fills the ring: set must win
        write_rptr(m_w);
        repeat (2) send_event();
        wait_idle();
        cfg_ovf_clr = 1;
        repeat (2) send_event();
        wait_idle();
        cfg_ovf_clr = 0;
        chk(wptr_word[31] == 1'b0, "R8", "clear after collision", wptr_word[31], 0);

        // ring disable clears state; stall mode with clamped size
        cfg_ring_en = 0; @(posedge clk); #1;
        chk(wptr_word == 0, "R1", "disable clears wptr", wptr_word, 0);
        chk(ev_ready == 0, "R1", "disable ready low", ev_ready, 0);
        cfg_ring_en = 1; cfg_ovf_en = 0; cfg_size_log2 = 4'd2;
        @(posedge clk); #1;
        send_event();
        wait_idle();
        ev_valid = 1'b1; @(posedge clk); #1;
        chk(ev_ready == 0, "R9", "stall when full", ev_ready, 0);
        ev_valid = 1'b0;
        write_rptr(32);
        chk(ev_ready == 1, "R9", "ready after space", ev_ready, 1);
        send_event();
        wait_idle();
        chk(wptr_word == 0, "R5", "wrap at clamped size", wptr_word, 0);

        // no writeback, irq masked, fast port
        throttle = 0;
        cfg_wb_en = 0; cfg_irq_en = 0; cfg_ovf_en = 1; cfg_size_log2 = 4'd6;
        write_rptr(m_w);
        repeat (3) send_event();
        wait_idle();
        chk(irq == 0, "R6", "irq masked", irq, 0);
        chk(mem_wvalid == 0, "R10", "no writeback", mem_wvalid, 0);
        cfg_irq_en = 1; @(posedge clk); #1;
        chk(irq == 1, "R6", "irq unmasked", irq, 1);
        write_rptr(m_w);
        chk(irq == 0, "R6", "irq after catch-up", irq, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule